// File: doc/BRIEF.md
# Serial EEPROM Bus Write Receiver

This block is the receiving half of a two-wire serial memory device's bus slave, limited to write transfers. It oversamples the clock and data lines on the system clock, finds START and STOP conditions, and takes in bytes on rising clock edges. The first byte after a START is checked against a fixed device code and the levels on three strapped select inputs. If they match and the memory is idle, the block acknowledges. The next byte becomes the word address. Every byte after that is offered to a downstream page buffer.

Each accepted data byte leaves the block as a one-cycle strobe. A running count of the bytes taken since the word address goes with it, and the buffer signals through a ready input whether it can take the byte. A STOP that ends an addressed write raises a one-cycle pulse, which tells the programming sequencer to begin. While that sequencer reports busy, the block does not acknowledge its address. A parameter selects a larger-array mode. In that mode the lowest select input is ignored, and the matching address-byte bit becomes bit 8 of the word pointer. The data line is driven only through an active-low pull-down enable.

Top module: `i2c_wr_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) returns the block to idle. Bits are taken on SCL rising edges, most significant bit first.
- R2: The address byte is acknowledged when all of the following hold: bits 7:4 equal 1010; bits 3:1 equal sel_i[2:0], with bit 3 compared to sel_i[2]; bit 0 (R/W) is 0. The acknowledge is sda_drive_n_o low throughout the high phase of the ninth SCL pulse.
- R3: An address byte that does not match, or that has R/W = 1, is not acknowledged. All bytes after it, up to the next START, are ignored: no acknowledge and no data strobe.
- R4: While busy_i is high when the address byte completes, the address is not acknowledged.
- R5: After an acknowledged address byte, the next byte is acknowledged and is loaded into addr_ptr_o[7:0]. In the default mode, addr_ptr_o[8] is 0.
- R6: With BIG_ARRAY = 1, sel_i[0] is ignored when matching. Address-byte bit 1 is loaded into addr_ptr_o[8].
- R7: A data byte that completes while buf_ready_i is high has three effects: it is acknowledged, it appears on data_o with a one-cycle data_valid_o pulse, and it increments byte_cnt_o. If buf_ready_i is low, the byte is not acknowledged, no strobe is given, and the rest of the transfer is ignored.
- R8: byte_cnt_o returns to 0 when a word address is accepted. Afterwards it equals the number of data bytes accepted in that transfer.
- R9: A START seen in the middle of a byte drops the partial byte and restarts address reception.
- R10: A STOP after an accepted word address gives a one-cycle wr_done_o pulse. Any other STOP gives none.
- R11: sda_drive_n_o changes only while SCL is low, and it is released after the ninth pulse.
- R12: After reset: sda_drive_n_o = 1, data_valid_o = 0, wr_done_o = 0, byte_cnt_o = 0, addr_ptr_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sel_i | input | 3 | Strapped chip-select levels |
| busy_i | input | 1 | Programming cycle in progress |
| buf_ready_i | input | 1 | Page buffer can take a byte |
| sda_drive_n_o | output | 1 | Active-low data line pull-down enable |
| addr_ptr_o | output | 9 | Word address pointer |
| data_o | output | 8 | Last accepted data byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| byte_cnt_o | output | CNT_W | Data bytes accepted since word address |
| wr_done_o | output | 1 | One-cycle pulse on STOP ending a write |

## Verification
Two events can land in the same bit period: a START arriving while a byte is partly shifted, and the ongoing shift of that byte. A directed case sends three bits of a byte and then issues a repeated START followed by a full write. The run passes only if the partial byte never reaches the buffer, and the pointer and captured data match the second transfer. Randomized writes also place a STOP right after a byte the buffer rejected. Those runs confirm that the completion pulse depends only on whether the word address was accepted.

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2,
  parameter bit         BIG_ARRAY   = 1'b0,
  parameter int         CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       sel_i,
  input  logic             busy_i,
  input  logic             buf_ready_i,
  output logic             sda_drive_n_o,
  output logic [8:0]       addr_ptr_o,
  output logic [7:0]       data_o,
  output logic             data_valid_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             wr_done_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WORD, ST_DATA} st_t;

  logic [SYNC_STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] nb;
  logic       drive, ack_q, armed;
  logic       sel_ok, addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign scl_d    = scl_sh[SYNC_STAGES];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign sda_d    = sda_sh[SYNC_STAGES];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  assign nb       = {shreg[6:0], sda_s};
  assign sel_ok   = BIG_ARRAY ? (nb[3:2] == sel_i[2:1]) : (nb[3:1] == sel_i);
  assign addr_hit = (nb[7:4] == DEV_CODE) & sel_ok & ~nb[0] & ~busy_i;

  assign sda_drive_n_o = ~drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      bitcnt       <= '0;
      shreg        <= '0;
      drive        <= 1'b0;
      ack_q        <= 1'b0;
      armed        <= 1'b0;
      addr_ptr_o   <= '0;
      data_o       <= '0;
      data_valid_o <= 1'b0;
      byte_cnt_o   <= '0;
      wr_done_o    <= 1'b0;
    end else begin
      data_valid_o <= 1'b0;
      wr_done_o    <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        drive  <= 1'b0;
        ack_q  <= 1'b0;
        armed  <= 1'b0;
      end else if (stop_c) begin
        wr_done_o <= armed;
        st        <= ST_IDLE;
        bitcnt    <= '0;
        drive     <= 1'b0;
        ack_q     <= 1'b0;
        armed     <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= nb;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              case (st)
                ST_ADDR: begin
                  ack_q <= addr_hit;
                  if (addr_hit) begin
                    st            <= ST_WORD;
                    addr_ptr_o[8] <= BIG_ARRAY ? nb[1] : 1'b0;
                  end else begin
                    st     <= ST_IDLE;
                    bitcnt <= '0;
                  end
                end
                ST_WORD: begin
                  ack_q           <= 1'b1;
                  armed           <= 1'b1;
                  addr_ptr_o[7:0] <= nb;
                  byte_cnt_o      <= '0;
                  st              <= ST_DATA;
                end
                default: begin
                  ack_q <= buf_ready_i;
                  if (buf_ready_i) begin
                    data_o       <= nb;
                    data_valid_o <= 1'b1;
                    byte_cnt_o   <= byte_cnt_o + 1'b1;
                  end else begin
                    st     <= ST_IDLE;
                    bitcnt <= '0;
                  end
                end
              endcase
            end
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            drive <= ack_q;
          end else if (bitcnt == 4'd9) begin
            drive  <= 1'b0;
            bitcnt <= '0;
          end
        end
      end
    end
  end

  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_n_o != $past(sda_drive_n_o)) |-> !$past(scl_s)); // R11
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |=> !data_valid_o); // R7
  AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> $past(buf_ready_i)); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> sda_drive_n_o); // R3
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_o |-> $past(stop_c)); // R10
  AST_START_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_c) |-> (!data_valid_o && !wr_done_o)); // R9

endmodule

// File: tb/i2c_wr_slave_tb.sv
module i2c_wr_slave_tb_top;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, busy = 1'b0, rdy = 1'b1;
  logic dn0, dn1, v0, v1, wd0, wd1;
  logic [8:0] p0, p1;
  logic [7:0] d0, d1;
  logic [3:0] c0, c1;
  int checks = 0, fails = 0;
  int cn0 = 0, cn1 = 0, dc0 = 0, dc1 = 0;
  logic [7:0] cap0 [0:15];
  logic [7:0] cap1 [0:15];
  logic [8:0] ep0 = '0, ep1 = '0;
  int ec0 = 0, ec1 = 0;
  localparam logic [2:0] SEL0 = 3'b101, SEL1 = 3'b010;

  always #4 clk = ~clk;

  i2c_wr_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sel_i(SEL0),
    .busy_i(busy), .buf_ready_i(rdy), .sda_drive_n_o(dn0), .addr_ptr_o(p0), .data_o(d0),
    .data_valid_o(v0), .byte_cnt_o(c0), .wr_done_o(wd0));
  i2c_wr_slave #(.BIG_ARRAY(1'b1)) dut_big_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sel_i(SEL1), .busy_i(busy), .buf_ready_i(rdy), .sda_drive_n_o(dn1), .addr_ptr_o(p1),
    .data_o(d1), .data_valid_o(v1), .byte_cnt_o(c1), .wr_done_o(wd1));

  always @(negedge clk) begin
    if (v0) begin cap0[cn0 % 16] <= d0; cn0 <= cn0 + 1; end
    if (v1) begin cap1[cn1 % 16] <= d1; cn1 <= cn1 + 1; end
    if (wd0) dc0 <= dc0 + 1;
    if (wd1) dc1 <= dc1 + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit addr_hit(input logic [7:0] a, input logic [2:0] s, input bit big, input bit bz);
    return (a[7:4] == 4'b1010) && !a[0] && !bz && (big ? (a[3:2] == s[2:1]) : (a[3:1] == s));
  endfunction

  task automatic i2c_start();
    sda = 1'b1; w(Q); scl = 1'b1; w(Q); sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda = 1'b0; w(Q); scl = 1'b1; w(Q); sda = 1'b1; w(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a0, output bit a1);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda = 1'b1; w(Q); scl = 1'b1; w(Q);
    a0 = !dn0; a1 = !dn1;
    w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic run_tx(input logic [7:0] ab, input logic [7:0] wa, input int n,
                        input logic [3:0] rmask, input bit bz);
    bit a0, a1, al0, al1, wk0, wk1;
    logic [7:0] dat [0:3];
    int b0, b1, e0, e1, dd0, dd1;
    b0 = cn0; b1 = cn1; dd0 = dc0; dd1 = dc1; e0 = 0; e1 = 0;
    busy = bz;
    i2c_start();
    send_byte(ab, a0, a1);
    al0 = addr_hit(ab, SEL0, 1'b0, bz);
    al1 = addr_hit(ab, SEL1, 1'b1, bz);
    chk(a0 == al0, "R2/R3/R4 addr ack", a0, al0);
    chk(a1 == al1, "R6 big addr ack", a1, al1);
    busy = 1'b0;
    send_byte(wa, a0, a1);
    chk(a0 == al0, "R5 word ack", a0, al0);
    chk(a1 == al1, "R5 word ack big", a1, al1);
    wk0 = al0; wk1 = al1;
    if (al0) begin ep0 = {1'b0, wa}; ec0 = 0; end
    if (al1) begin ep1 = {ab[1], wa}; ec1 = 0; end
    for (int i = 0; i < n; i++) begin
      dat[i] = 8'($urandom);
      rdy = rmask[i];
      send_byte(dat[i], a0, a1);
      al0 = al0 & rmask[i]; al1 = al1 & rmask[i];
      chk(a0 == al0, "R7 data ack", a0, al0);
      chk(a1 == al1, "R7 data ack big", a1, al1);
      if (al0) begin chk(cap0[(b0 + e0) % 16] == dat[i], "R7 data value", cap0[(b0 + e0) % 16], dat[i]); e0++; ec0++; end
      if (al1) begin chk(cap1[(b1 + e1) % 16] == dat[i], "R7 data value big", cap1[(b1 + e1) % 16], dat[i]); e1++; ec1++; end
    end
    rdy = 1'b1;
    i2c_stop();
    chk(cn0 - b0 == e0, "R3/R7 strobe count", cn0 - b0, e0);
    chk(cn1 - b1 == e1, "R3/R7 strobe count big", cn1 - b1, e1);
    chk(p0 == ep0, "R5 pointer", p0, ep0);
    chk(p1 == ep1, "R6 pointer big", p1, ep1);
    chk(c0 == 4'(ec0), "R8 byte count", c0, ec0);
    chk(c1 == 4'(ec1), "R8 byte count big", c1, ec1);
    chk(dc0 - dd0 == int'(wk0), "R10 done pulse", dc0 - dd0, wk0);
    chk(dc1 - dd1 == int'(wk1), "R10 done pulse big", dc1 - dd1, wk1);
    chk(dn0 && dn1, "R11 released after stop", {dn0, dn1}, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ab;
    bit x0, x1;
    int cb;
    void'($urandom(32'd4711));
    w(5); rst_n = 1'b1; w(2);
    // R12 reset state
    chk(dn0 && dn1 && !v0 && !v1 && !wd0 && !wd1, "R12 reset outputs", {dn0, v0, wd0}, 4);
    chk(p0 == 0 && p1 == 0 && c0 == 0 && c1 == 0, "R12 reset pointer/count", p0, 0);
    // R1/R2 directed write to default-mode device
    run_tx({4'b1010, SEL0, 1'b0}, 8'h5A, 2, 4'b1111, 1'b0);
    // R4 busy blocks ack
    run_tx({4'b1010, SEL0, 1'b0}, 8'h11, 1, 4'b1111, 1'b1);
    // R3 read request is not taken
    run_tx({4'b1010, SEL0, 1'b1}, 8'h22, 1, 4'b1111, 1'b0);
    // R6 upper block with sel_i[0] ignored
    run_tx({4'b1010, 2'b01, 1'b1, 1'b0}, 8'hC3, 3, 4'b1111, 1'b0);
    // R7 buffer rejects the first data byte
    run_tx({4'b1010, SEL0, 1'b0}, 8'h40, 3, 4'b1110, 1'b0);
    // R9 repeated START in the middle of a byte
    cb = cn0;
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start();
    send_byte({4'b1010, SEL0, 1'b0}, x0, x1);
    chk(x0, "R9 ack after restart", x0, 1);
    send_byte(8'h3C, x0, x1);
    send_byte(8'h77, x0, x1);
    i2c_stop();
    chk(p0 == 9'h03C, "R9 pointer after restart", p0, 9'h03C);
    chk(cn0 - cb == 1 && cap0[cb % 16] == 8'h77, "R9 capture after restart", cap0[cb % 16], 8'h77);
    ep0 = 9'h03C; ec0 = 1;
    // randomized writes
    for (int t = 0; t < 36; t++) begin
      case ($urandom % 4)
        0: ab = {4'b1010, SEL0, 1'b0};
        1: ab = {4'b1010, 2'b01, 1'($urandom), 1'b0};
        2: ab = {4'b1010, 3'($urandom), 1'($urandom)};
        default: ab = 8'($urandom);
      endcase
      run_tx(ab, 8'($urandom), 1 + int'($urandom % 4), ($urandom % 3 == 0) ? 4'($urandom) : 4'hF,
             ($urandom % 5) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule